// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Host Read Port

This block sequences an 8-bit successive-approximation conversion around an external DAC and comparator, then presents the result to a host on a parallel read port. Each conversion opens with a short acquisition phase in which the trial code sits at half scale and the track/hold follows the input. The hold command is then raised and eight decisions follow, one per clock, each settling one bit from the most significant down. After the last decision the settled code is copied into an output latch, the trial code returns to half scale and the busy flag is released.

A host starts a conversion by pulling chip-select and read low together. The mode input selects how that strobe behaves. In slow-memory mode the host is stalled on busy and reads the fresh result once busy releases. In ROM mode the strobe returns the previously latched result at once and launches a new conversion in the background. In free-running mode conversions repeat back to back with no host request, and a read only returns the latch.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset busy_n is 1, hold is 0, dac_code is 0x80 (half scale: only the MSB set), data_oe is 0 and data_out is 0.
- R2: With mode 2'b01 (slow-memory) or 2'b10/2'b11 (ROM), a new low level on both cs_n and rd_n while idle pulls busy_n low in that same cycle and starts a conversion at the next rising edge. dac_code stays 0x80 until the first decision.
- R3: hold is raised by the second rising edge after the start edge, stays 1 through all decisions, and returns to 0 when the conversion ends.
- R4: Each decision edge sets the trial bit to comp_hi, where 1 means the input is above the trial code and keeps the bit, and 0 clears it. The same edge sets the next lower bit as the new trial bit. The result equals the input code.
- R5: Exactly eight decisions take place on edges 3 to 10 after the start edge. On edge 10 busy_n returns high, the output latch takes the result, dac_code returns to 0x80 and hold drops. The latch does not change while busy_n is low.
- R6: In slow-memory mode data_oe stays 0 while busy_n is low and rises with busy_n, presenting the new result while the strobe is still held.
- R7: In ROM mode the strobe drives data_oe high at once with the previous result and also starts a new conversion.
- R8: With mode 2'b00 (free-running) a new conversion starts on the edge after the previous one ends, so busy_n is high for exactly one cycle between conversions. No strobe is needed.
- R9: A strobe edge arriving during a conversion is ignored, and a strobe held low past the end does not start another conversion.
- R10: data_oe is 1 only while cs_n and rd_n are both low. Otherwise data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| mode | input | 2 | 00 free-run, 01 slow-memory, 10/11 ROM |
| comp_hi | input | 1 | Comparator: 1 when input is above dac_code |
| dac_code | output | W | Trial code applied to the DAC |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy_n | output | 1 | Low while converting, also the host ready line |
| data_out | output | W | Latched result, 0 when not enabled |
| data_oe | output | 1 | Data output enable (models high impedance when 0) |

## Verification
Counting the start edge as edge 0, busy_n falls combinationally in the strobe cycle, hold is due after edge 2, trial codes after edges 3 to 9, and the result, released busy and half-scale code after edge 10. A monitor finds each falling busy_n at a falling clock edge and pops the expected input code from a queue filled by the driver tasks. It then counts falling edges and compares every output against the value due for that cycle. Driver tasks change inputs just after a falling edge and sample one time step later, so the strobe-cycle results (busy_n, data_oe, ROM data) are read before the next rising edge.

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int W = 8,
  parameter int HOLD_EDGE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic [1:0]   mode,
  input  logic         comp_hi,
  output logic [W-1:0] dac_code,
  output logic         hold,
  output logic         busy_n,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = (HOLD_EDGE > 2) ? $clog2(HOLD_EDGE) : 1;
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
  localparam logic [1:0] M_FREE = 2'b00;
  localparam logic [1:0] M_SLOW = 2'b01;

  logic          busy_q, acq_q, hold_q, req_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitp;
  logic [W-1:0]  sar, sar_dec, out_q;
  logic          req, host_start, start;

  assign req        = ~cs_n & ~rd_n;
  assign host_start = req & ~req_q & ~busy_q & (mode != M_FREE);
  assign start      = host_start | (~busy_q & (mode == M_FREE));

  always_comb begin
    sar_dec = sar;
    sar_dec[bitp] = comp_hi;
    if (bitp != '0) sar_dec[bitp - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      acq_q  <= 1'b0;
      hold_q <= 1'b0;
      req_q  <= 1'b0;
      cnt    <= '0;
      bitp   <= '0;
      sar    <= HALF;
      out_q  <= '0;
    end else begin
      req_q <= req;
      if (start) begin
        busy_q <= 1'b1;
        acq_q  <= 1'b1;
        cnt    <= CW'(1);
        sar    <= HALF;
      end else if (busy_q) begin
        if (acq_q) begin
          if (cnt == CW'(HOLD_EDGE - 1)) begin
            acq_q  <= 1'b0;
            hold_q <= 1'b1;
            bitp   <= BW'(W - 1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (bitp == '0) begin
          out_q  <= sar_dec;
          busy_q <= 1'b0;
          hold_q <= 1'b0;
          sar    <= HALF;
        end else begin
          sar  <= sar_dec;
          bitp <= bitp - 1'b1;
        end
      end
    end
  end

  assign dac_code = sar;
  assign hold     = hold_q;
  assign busy_n   = ~(busy_q | host_start);
  assign data_oe  = req & ((mode == M_SLOW) ? busy_n : 1'b1);
  assign data_out = data_oe ? out_q : '0;
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic [1:0]   mode,
  input logic [W-1:0] dac_code,
  input logic         hold,
  input logic         busy_n,
  input logic         data_oe,
  input logic [W-1:0] out_q
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  // R2
  start_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> dac_code == HALF);

  // R3
  hold_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !busy_n);

  // R5
  end_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (dac_code == HALF && !hold));

  // R5
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> ($stable(out_q) || busy_n));

  // R6
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && mode == 2'b01) |-> busy_n);

  // R10
  oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n && !rd_n));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .mode(mode),
  .dac_code(dac_code), .hold(hold), .busy_n(busy_n), .data_oe(data_oe),
  .out_q(out_q)
);

// File: tb/sar_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sar_bus_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       comp_hi;
  logic [7:0] dac_code, data_out;
  logic       hold, busy_n, data_oe;
  logic [7:0] v_cur = 8'h00;

  int total = 0, bad = 0, done_cnt = 0;
  logic [7:0] q[$];
  logic [7:0] exp_latch = 8'h00;
  logic [7:0] cur_v = 8'h00;
  logic       prev_b = 1'b1, in_conv = 1'b0;
  int         n = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;
  assign comp_hi = (dac_code <= v_cur);

  sar_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .mode(mode),
    .comp_hi(comp_hi), .dac_code(dac_code), .hold(hold), .busy_n(busy_n),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] trial(input logic [7:0] v, input int k);
    logic [7:0] m;
    m = ~((8'h01 << (8 - k)) - 8'h01);
    return (v & m) | (8'h01 << (7 - k));
  endfunction

  // monitor: pops expected code at each conversion start and tracks its timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_conv) begin
        n++;
        if (n < 10) chk(busy_n == 1'b0, "R5 busy low", busy_n, 0);
        if (n == 1) chk(hold == 1'b0, "R3 track before hold", hold, 0);
        if (n >= 2 && n <= 9) chk(hold == 1'b1, "R3 hold", hold, 1);
        if (n == 2) chk(dac_code == 8'h80, "R2 half scale", dac_code, 8'h80);
        if (n >= 3 && n <= 9)
          chk(dac_code == trial(cur_v, n - 2), "R4 trial code", dac_code, trial(cur_v, n - 2));
        if (n == 10) begin
          chk(busy_n == 1'b1, "R5 busy release", busy_n, 1);
          chk(dac_code == 8'h80, "R5 half after end", dac_code, 8'h80);
          chk(hold == 1'b0, "R3 hold drop", hold, 0);
          exp_latch = cur_v;
          in_conv = 1'b0;
          done_cnt++;
        end
      end else if (prev_b && !busy_n) begin
        if (q.size() == 0) chk(1'b0, "R9 unexpected conversion", 1, 0);
        else cur_v = q.pop_front();
        chk(dac_code == 8'h80 && hold == 1'b0, "R2 start state", dac_code, 8'h80);
        in_conv = 1'b1;
        n = 0;
      end
      prev_b = busy_n;
    end
  end

  task automatic wait_done();
    int d0;
    d0 = done_cnt;
    wait (done_cnt == d0 + 1);
    #1;
  endtask

  task automatic slow_read(input logic [7:0] v);
    @(negedge clk); #1;
    v_cur = v; q.push_back(v);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(busy_n == 1'b0, "R2 busy in strobe cycle", busy_n, 0);
    chk(data_oe == 1'b0, "R6 no data while busy", data_oe, 0);
    wait_done();
    chk(data_oe == 1'b1, "R6 oe with ready", data_oe, 1);
    chk(data_out == v, "R6 new result", data_out, v);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(busy_n == 1'b1, "R9 held strobe no restart", busy_n, 1);
    end
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic rom_read(input logic [7:0] v);
    logic [7:0] prev;
    prev = exp_latch;
    @(negedge clk); #1;
    v_cur = v; q.push_back(v);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(data_oe == 1'b1, "R7 immediate oe", data_oe, 1);
    chk(data_out == prev, "R7 previous result", data_out, prev);
    chk(busy_n == 1'b0, "R7 conversion started", busy_n, 0);
    @(negedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(data_out == prev, "R9 latch unchanged mid conversion", data_out, prev);
    @(negedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
    wait_done();
    repeat (3) @(negedge clk);
    #1;
    chk(busy_n == 1'b1, "R9 mid strobe ignored", busy_n, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
    chk(hold == 1'b0, "R1 hold", hold, 0);
    chk(dac_code == 8'h80, "R1 dac", dac_code, 8'h80);
    chk(data_oe == 1'b0 && data_out == 8'h00, "R1 data", data_out, 0);
    rst_n = 1'b1;

    @(negedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (3) begin
      @(negedge clk); #1;
      chk(data_oe == 1'b0 && data_out == 8'h00, "R10 cs high", data_out, 0);
      chk(busy_n == 1'b1, "R10 no start", busy_n, 1);
    end
    cs_n = 1'b0; rd_n = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(data_oe == 1'b0 && data_out == 8'h00, "R10 rd high", data_out, 0);
    end
    cs_n = 1'b1;

    mode = 2'b01;
    slow_read(8'hA5);
    slow_read(8'h00);
    slow_read(8'hFF);
    slow_read(8'h80);
    slow_read(8'h7F);

    mode = 2'b10;
    rom_read(8'h3C);
    rom_read(8'hC3);
    rom_read(8'h01);

    @(negedge clk); #1;
    v_cur = 8'h5A; q.push_back(8'h5A);
    mode = 2'b00;
    wait_done();
    v_cur = 8'hE1; q.push_back(8'hE1);
    chk(busy_n == 1'b1, "R8 one idle cycle", busy_n, 1);
    @(negedge clk); #1;
    chk(busy_n == 1'b0, "R8 back to back", busy_n, 0);
    wait_done();
    mode = 2'b01;
    repeat (4) @(negedge clk);
    #1;
    chk(busy_n == 1'b1, "R8 stop on mode change", busy_n, 1);

    mode = 2'b10;
    @(negedge clk); #1;
    cs_n = 1'b0; rd_n = 1'b0; q.push_back(v_cur);
    #1;
    chk(data_out == 8'hE1, "R8 free-run result readable", data_out, 8'hE1);
    @(negedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
    wait_done();

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all conversions seen", q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule